// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block gives a host a byte-wide, memory-mapped view of a PC-style parallel printer port. Four registers sit behind a simple bus made of an address, a read strobe, a write strobe, write data and read data. They hold the outgoing data byte, the sampled printer status lines, the port's control lines and a configuration byte that selects the operating mode and reports two FIFO flags.

On the pin side the block drives the eight data lines through an output latch and an output enable. It drives four control lines and samples five status lines. Every incoming pin passes through a synchroniser before it is used. The block applies each pin's own polarity rule. It releases the data lines only in the enhanced parallel (EPP) mode, when the host asks for input. An acknowledge edge latches an interrupt request, and the control register decides whether that request reaches the interrupt output. Handshake sequencing and the FIFO storage are outside the block, so the FIFO flags arrive as plain inputs.

Top module: `pport_regblk`

## Requirements
- R1: After reset every register is 0 and the mode is standard (000). The pins then read: strobe, autofeed and select high, init low, data out 0x00, data output enable 1, interrupt 0.
- R2: The registers sit at these offsets: data 0x000, status 0x001, control 0x002 and configuration 0x402. A read of any other address returns 0x00, and a write to any other address changes no register.
- R3: A write to the data register loads the output latch, and `pd_out` shows the latch one cycle later. In every mode other than EPP (mode 100), a data read returns the latch and `pd_oe` stays 1, whatever the value of control bit 5.
- R4: In EPP mode with control bit 5 at 1, `pd_oe` is 0. A data read then returns the data pins as they were SYNC_STAGES clock edges earlier.
- R5: Pin polarity is fixed per bit. Control bit 0 (strobe), bit 1 (autofeed) and bit 3 (select) drive their pins low when set. Bit 2 (init) drives its pin high when set.
- R6: A control read returns bits 5:0 as written, with bits 7:6 reading 0.
- R7: The status byte is built as follows. Bit 7 reads 1 when the busy pin is low. Bits 6, 5, 4 and 3 read 1 when the acknowledge, paper-end, select-in and error pins are high, in that order. Bits 2:1 read 0. Each pin change shows SYNC_STAGES edges after it is applied, and not before.
- R8: A high `timeout_pulse` sets status bit 0. Writing 1 to status bit 0 clears it. Writing 0 to that bit leaves it unchanged.
- R9: A rising edge of the synchronised acknowledge line sets a pending flag, and `irq` equals pending AND control bit 4. A flag that is already pending raises `irq` as soon as bit 4 is set.
- R10: A status read clears the pending flag, so `irq` falls after that read. A falling acknowledge edge sets nothing.
- R11: Configuration bits 7:5 hold the mode written by the host. Bit 0 reflects `fifo_empty`, bit 1 reflects `fifo_full`, and bits 4:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address offset |
| bus_rd | input | 1 | Read strobe; a status read clears the pending interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| pd_in | input | 8 | Sampled data lines |
| pd_out | output | 8 | Data line drive value |
| pd_oe | output | 1 | Data line output enable, 1 = drive |
| strobe_pin | output | 1 | Strobe line level |
| autofd_pin | output | 1 | Autofeed line level |
| init_pin | output | 1 | Init line level |
| select_pin | output | 1 | Select line level |
| err_pin | input | 1 | Error status line |
| selin_pin | input | 1 | Select-in status line |
| pe_pin | input | 1 | Paper-end status line |
| ack_pin | input | 1 | Acknowledge status line |
| busy_pin | input | 1 | Busy status line |
| timeout_pulse | input | 1 | Sets the timeout flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults, ADDR_W = 11 and SYNC_STAGES = 2. The 11-bit address reaches the configuration offset 0x402, and the bench also aliases it with the unmapped 0x401. With two synchroniser stages, the bench can read a status pin after one edge and expect the old value, then after the second edge and expect the new one. The same depth fixes the three-edge path from an acknowledge pin edge to `irq`, which the interrupt scenarios time against.

// File: rtl/pport_regblk.sv
module pport_regblk #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pd_in,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  output logic              strobe_pin,
  output logic              autofd_pin,
  output logic              init_pin,
  output logic              select_pin,
  input  logic              err_pin,
  input  logic              selin_pin,
  input  logic              pe_pin,
  input  logic              ack_pin,
  input  logic              busy_pin,
  input  logic              timeout_pulse,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(11'h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(11'h001);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(11'h002);
  localparam logic [ADDR_W-1:0] A_CONF = ADDR_W'(11'h402);
  localparam logic [2:0]        M_EPP  = 3'b100;
  localparam int                SW     = 13;

  logic [7:0]    lat_q;
  logic [5:0]    ctrl_q;
  logic [2:0]    mode_q;
  logic          to_q, pend_q, ack_d;
  logic [SW-1:0] sync_q [SYNC_STAGES];
  logic [SW-1:0] s;
  logic          ack_rise, in_mode;
  logic [7:0]    stat_v;

  assign s        = sync_q[SYNC_STAGES-1];
  assign ack_rise = s[11] & ~ack_d;
  assign in_mode  = (mode_q == M_EPP) && ctrl_q[5];
  assign stat_v   = {~s[12], s[11], s[10], s[9], s[8], 2'b00, to_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      ack_d <= 1'b0;
    end else begin
      sync_q[0] <= {busy_pin, ack_pin, pe_pin, selin_pin, err_pin, pd_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      ack_d <= s[11];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      ctrl_q <= '0;
      mode_q <= '0;
      to_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_DATA) lat_q  <= bus_wdata;
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[5:0];
      if (bus_wr && bus_addr == A_CONF) mode_q <= bus_wdata[7:5];
      if (timeout_pulse) to_q <= 1'b1;
      else if (bus_wr && bus_addr == A_STAT && bus_wdata[0]) to_q <= 1'b0;
      if (ack_rise) pend_q <= 1'b1;
      else if (bus_rd && bus_addr == A_STAT) pend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata = in_mode ? s[7:0] : lat_q;
        A_STAT:  bus_rdata = stat_v;
        A_CTRL:  bus_rdata = {2'b00, ctrl_q};
        A_CONF:  bus_rdata = {mode_q, 3'b000, fifo_full, fifo_empty};
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  assign pd_out     = lat_q;
  assign pd_oe      = ~in_mode;
  assign strobe_pin = ~ctrl_q[0];
  assign autofd_pin = ~ctrl_q[1];
  assign init_pin   =  ctrl_q[2];
  assign select_pin = ~ctrl_q[3];
  assign irq        = pend_q & ctrl_q[4];
endmodule

// File: rtl/pport_regblk_chk.sv
module pport_regblk_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        pd_out,
  input logic              pd_oe,
  input logic              strobe_pin,
  input logic              irq,
  input logic              timeout_pulse,
  input logic              to_q,
  input logic [2:0]        mode_q,
  input logic              ack_rise
);
  // R3
  data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> pd_out == $past(bus_wdata));

  // R4
  dir_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_oe |-> mode_q == 3'b100);

  // R5
  strobe_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> strobe_pin == !$past(bus_wdata[0]));

  // R8
  timeout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> to_q);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1) && !ack_rise) |=> !irq);
endmodule

bind pport_regblk pport_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pport_regblk.sv
`timescale 1ns/1ps
module sim_pport_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pd_in = '0;
  logic [7:0]  pd_out;
  logic        pd_oe, strobe_pin, autofd_pin, init_pin, select_pin, irq;
  logic        err_pin = 0, selin_pin = 0, pe_pin = 0, ack_pin = 0, busy_pin = 0;
  logic        timeout_pulse = 0, fifo_empty = 0, fifo_full = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  pport_regblk u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pins", {pd_oe, strobe_pin, autofd_pin, init_pin, select_pin, irq, 2'b0}, 8'b1110_1000);
    check("R1 pd_out", pd_out, 8'h00);
    rd(11'h002, v); check("R1 ctrl", v, 8'h00);
    rd(11'h402, v); check("R1 conf", v, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] v;
    wr(11'h000, 8'hA5); check("R3 pd_out", pd_out, 8'hA5);
    rd(11'h000, v); check("R3 latch read", v, 8'hA5);
    pd_in = 8'h3C;
    wr(11'h402, 8'h20); wr(11'h002, 8'h20); idle(3);
    check("R3 oe byte mode", {7'b0, pd_oe}, 8'h01);
    rd(11'h000, v); check("R3 byte mode read", v, 8'hA5);
    wr(11'h402, 8'h80); check("R4 oe", {7'b0, pd_oe}, 8'h00);
    rd(11'h000, v); check("R4 pin read", v, 8'h3C);
    pd_in = 8'h5A; idle(1);
    rd(11'h000, v); check("R4 pin read 2", v, 8'h5A);
    wr(11'h002, 8'h00); check("R4 oe restored", {7'b0, pd_oe}, 8'h01);
    wr(11'h402, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(11'h002, 8'hFF);
    check("R5 pins set", {4'b0, strobe_pin, autofd_pin, init_pin, select_pin}, 8'b0000_0010);
    rd(11'h002, v); check("R6 ctrl read", v, 8'h3F);
    wr(11'h002, 8'h05);
    check("R5 pins mixed", {4'b0, strobe_pin, autofd_pin, init_pin, select_pin}, 8'b0000_0111);
    wr(11'h002, 8'h00);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    wr(11'h002, 8'h0A); wr(11'h003, 8'hFF); wr(11'h401, 8'hFF);
    rd(11'h002, v); check("R2 ctrl untouched", v, 8'h0A);
    rd(11'h000, v); check("R2 data untouched", v, 8'hA5);
    rd(11'h402, v); check("R2 conf untouched", v, 8'h00);
    rd(11'h003, v); check("R2 unmapped read", v, 8'h00);
    wr(11'h002, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    @(negedge clk); busy_pin = 0; ack_pin = 1; pe_pin = 0; selin_pin = 1; err_pin = 1;
    @(negedge clk); bus_addr = 11'h001; bus_rd = 1; #1 v = bus_rdata;
    check("R7 one edge old", v, 8'h80);
    @(negedge clk); #1 v = bus_rdata; bus_rd = 0;
    check("R7 pattern a", v, 8'hD8);
    idle(3); rd(11'h001, v);
    @(negedge clk); busy_pin = 1; ack_pin = 0; pe_pin = 1; selin_pin = 0; err_pin = 0;
    idle(3); rd(11'h001, v); check("R7 pattern b", v, 8'h20);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    @(negedge clk); timeout_pulse = 1; @(negedge clk); timeout_pulse = 0;
    rd(11'h001, v); check("R8 set", v, 8'h21);
    wr(11'h001, 8'hFE); rd(11'h001, v); check("R8 write 0 kept", v, 8'h21);
    wr(11'h001, 8'h01); rd(11'h001, v); check("R8 clear", v, 8'h20);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(11'h002, 8'h10);
    @(negedge clk); ack_pin = 1; idle(4);
    check("R9 irq raised", {7'b0, irq}, 8'h01);
    rd(11'h001, v); check("R10 cleared by read", {7'b0, irq}, 8'h00);
    @(negedge clk); ack_pin = 0; idle(4);
    check("R10 fall no irq", {7'b0, irq}, 8'h00);
    wr(11'h002, 8'h00);
    @(negedge clk); ack_pin = 1; idle(4);
    check("R9 masked", {7'b0, irq}, 8'h00);
    wr(11'h002, 8'h10);
    check("R9 late enable", {7'b0, irq}, 8'h01);
    rd(11'h001, v); wr(11'h002, 8'h00);
  endtask

  task automatic t_conf();
    logic [7:0] v;
    fifo_empty = 1; fifo_full = 0;
    wr(11'h402, 8'hFF); rd(11'h402, v); check("R11 mode 111 empty", v, 8'hE1);
    fifo_empty = 0; fifo_full = 1;
    wr(11'h402, 8'h60); rd(11'h402, v); check("R11 mode 011 full", v, 8'h62);
    wr(11'h402, 8'h00);
  endtask

  initial begin
    idle(4); rst_n = 1; idle(1);
    t_reset(); t_data(); t_ctrl(); t_addr(); t_status();
    t_timeout(); t_irq(); t_conf();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule